// File: doc/BRIEF.md
# Memory Wait-State Cycle Calculator

This block tells a bus master what one memory access costs in clock cycles on a 32-bit system bus. Each request carries an address, a sequential/non-sequential flag, an access width and a sampled video "horizontal drawing" status bit. The block looks at the top address byte to pick a memory region and adds up a cost. For the three cartridge regions, the cost comes from two small lookup tables. Fields of a 16-bit wait-control register select the table entries.

The wait-control register is loaded through a simple write strobe with data and is read back continuously on a read-data port. A request strobe is captured on one rising edge. On the next edge the cost appears on a registered output together with a one-cycle valid pulse. The cost output holds its value until the next request.

Top module: `wait_cost_calc`

## Requirements
- R1: While reset is low and after its release, `regRdData` is 0x0000, `costValid` is 0 and `costCycles` is 0 until the first request or write.
- R2: When `reqValid` is high at a rising edge, `costValid` is high for exactly the following cycle and `costCycles` shows the cost of that request. With no request, `costValid` is low and `costCycles` holds its last value.
- R3: Address byte 0x02 (bits 31:24) costs 6 cycles for a 32-bit access and 3 cycles otherwise.
- R4: Address bytes 0x05, 0x06 and 0x07 cost 2 cycles for a 32-bit access and 1 cycle otherwise. One more cycle is added when `hDrawActive` is high in the request cycle.
- R5: A cartridge access (address byte 0x08, 0x0A or 0x0C) that is non-sequential (`reqSeq`=0) and narrower than 32 bits costs 4, 3, 2 or 8 cycles for first-access field values 0, 1, 2 and 3.
- R6: A sequential (`reqSeq`=1) cartridge access narrower than 32 bits costs 2 cycles when the region's second-access bit is 0 and 1 cycle when it is 1.
- R7: A 32-bit non-sequential cartridge access costs the R5 value plus the R6 value. A 32-bit sequential cartridge access costs twice the R6 value.
- R8: Register field positions are as follows. Region 0x08 uses bits 3:2 as its first-access field and bit 4 as its second-access bit. Region 0x0A uses bits 6:5 and bit 7. Region 0x0C uses bits 9:8 and bit 10. Each region's cost depends only on its own fields.
- R9: Every other address byte, including 0x00, 0x01, 0x03, 0x04, 0x09 and 0xFF, costs 0 cycles.
- R10: A write (`regWrEn`=1) stores all 16 bits of `regWrData`, which then read back on `regRdData` from the next cycle. Bits 1:0, 12:11, 13, 14 and 15 are stored but have no effect on any cost.
- R11: When a write and a request fall in the same cycle, that request is costed with the register value from before the write. The new value applies from the next request on.
- R12: Width encoding is 2'b00 for 8-bit, 2'b01 for 16-bit and 2'b10 for 32-bit. Code 2'b11 is costed as a narrow access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one access per high cycle |
| reqAddr | input | 32 | Access address; bits 31:24 select the region |
| reqSeq | input | 1 | 1 = sequential access, 0 = non-sequential |
| reqWidth | input | 2 | Access width code (see R12) |
| hDrawActive | input | 1 | Video horizontal-drawing status, sampled with the request |
| regWrEn | input | 1 | Wait-control register write strobe |
| regWrData | input | 16 | Wait-control register write data |
| regRdData | output | 16 | Current wait-control register contents |
| costValid | output | 1 | One-cycle pulse when a new cost is presented |
| costCycles | output | 5 | Cycle cost of the last captured request |

## Verification
A register write and a request can land on the same rising edge. The request must then be costed with the old field values while the register takes the new ones. The bench provokes this with a cartridge request whose first-access field changes from 0 to 3 in that same cycle. It expects 4 cycles for that request and 8 cycles for an identical request issued right after. The register read-back is also checked in the same step, so both halves of the collision are judged together.

// File: rtl/wscalc_pkg.sv
package wscalc_pkg;

  localparam int unsigned COST_W = 5;

  typedef logic [COST_W-1:0] cost_t;

  typedef enum logic [1:0] {
    WIDTH_8   = 2'b00,
    WIDTH_16  = 2'b01,
    WIDTH_32  = 2'b10,
    WIDTH_RSV = 2'b11
  } accWidth_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureReq;
    logic loadCtl;
  } ctlStrobes_t;

  // non-sequential cartridge cost, indexed by a 2-bit field
  function automatic cost_t firstCost(input logic [1:0] idx);
    case (idx)
      2'd0:    firstCost = cost_t'(4);
      2'd1:    firstCost = cost_t'(3);
      2'd2:    firstCost = cost_t'(2);
      default: firstCost = cost_t'(8);
    endcase
  endfunction

  // sequential cartridge cost, indexed by a 1-bit field
  function automatic cost_t secondCost(input logic idx);
    secondCost = idx ? cost_t'(1) : cost_t'(2);
  endfunction

endpackage

// File: rtl/wscalc_ctrl.sv
module wscalc_ctrl
  import wscalc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        regWrEn,
  output ctlStrobes_t strobes,
  output logic        costValid
);

  always_comb begin
    strobes.captureReq = reqValid;
    strobes.loadCtl    = regWrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) costValid <= 1'b0;
    else       costValid <= reqValid;
  end

endmodule

// File: rtl/wscalc_dp.sv
module wscalc_dp
  import wscalc_pkg::*;
#(
  parameter int unsigned REG_W    = 16,
  parameter int unsigned NUM_CART = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic [7:0]       regionByte,
  input  logic             reqSeq,
  input  logic [1:0]       reqWidth,
  input  logic             hDrawActive,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output cost_t            costCycles
);

  localparam logic [7:0] EXT_RAM   = 8'h02;
  localparam logic [7:0] PAL_RAM   = 8'h05;
  localparam logic [7:0] VID_RAM   = 8'h06;
  localparam logic [7:0] OBJ_RAM   = 8'h07;
  localparam logic [7:0] CART_BASE = 8'h08;
  localparam int unsigned FIELD_LSB  = 2;
  localparam int unsigned FIELD_STEP = 3;

  logic [REG_W-1:0] waitCtl;
  cost_t            nsCost [NUM_CART];
  cost_t            sqCost [NUM_CART];
  cost_t            nextCost;

  always_ff @(posedge clk) begin
    if (!rstN)                waitCtl <= '0;
    else if (strobes.loadCtl) waitCtl <= regWrData;
  end

  assign regRdData = waitCtl;

  // per-region table lookups
  for (genvar k = 0; k < NUM_CART; k++) begin : g_cart
    localparam int unsigned BASE = FIELD_LSB + FIELD_STEP * k;
    assign nsCost[k] = firstCost(waitCtl[BASE +: 2]);
    assign sqCost[k] = secondCost(waitCtl[BASE + 2]);
  end

  always_comb begin
    logic  isWide;
    cost_t ns;
    cost_t sq;
    logic  cartHit;
    isWide  = (reqWidth == WIDTH_32);
    ns      = '0;
    sq      = '0;
    cartHit = 1'b0;
    for (int k = 0; k < NUM_CART; k++) begin
      if (regionByte == CART_BASE + 8'(2 * k)) begin
        cartHit = 1'b1;
        ns      = nsCost[k];
        sq      = sqCost[k];
      end
    end
    nextCost = '0;
    if (cartHit) begin
      if (reqSeq) nextCost = isWide ? cost_t'(sq + sq) : sq;
      else        nextCost = isWide ? cost_t'(ns + sq) : ns;
    end else begin
      case (regionByte)
        EXT_RAM:                   nextCost = isWide ? cost_t'(6) : cost_t'(3);
        PAL_RAM, VID_RAM, OBJ_RAM: nextCost = (isWide ? cost_t'(2) : cost_t'(1))
                                              + cost_t'(hDrawActive);
        default:                   nextCost = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   costCycles <= '0;
    else if (strobes.captureReq) costCycles <= nextCost;
  end

endmodule

// File: rtl/wait_cost_calc.sv
module wait_cost_calc
  import wscalc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned REG_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqSeq,
  input  logic [1:0]        reqWidth,
  input  logic              hDrawActive,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              costValid,
  output logic [COST_W-1:0] costCycles
);

  ctlStrobes_t strobes;

  wscalc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .regWrEn   (regWrEn),
    .strobes   (strobes),
    .costValid (costValid)
  );

  wscalc_dp #(.REG_W(REG_W), .NUM_CART(3)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .regionByte  (reqAddr[ADDR_W-1 -: 8]),
    .reqSeq      (reqSeq),
    .reqWidth    (reqWidth),
    .hDrawActive (hDrawActive),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .costCycles  (costCycles)
  );

endmodule

// File: rtl/wscalc_checker.sv
module wscalc_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned REG_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqSeq,
  input logic [1:0]        reqWidth,
  input logic              hDrawActive,
  input logic              regWrEn,
  input logic [REG_W-1:0]  regWrData,
  input logic [REG_W-1:0]  regRdData,
  input logic              costValid,
  input logic [4:0]        costCycles
);

  logic [7:0] topByte;
  assign topByte = reqAddr[ADDR_W-1 -: 8];

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> costValid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !costValid); // R2
  AST_COST_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(costCycles)); // R2
  AST_ADDR_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !$isunknown(reqAddr)); // R2
  AST_EXT_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && topByte == 8'h02 && reqWidth == 2'b10) |=> costCycles == 5'd6); // R3
  AST_VIDEO_HDRAW: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && topByte == 8'h06 && reqWidth != 2'b10 && hDrawActive) |=> costCycles == 5'd2); // R4
  AST_CART_SEQ_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && topByte == 8'h08 && reqSeq && reqWidth == 2'b10 && regRdData[4]) |=> costCycles == 5'd2); // R7
  AST_INTERNAL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && topByte == 8'h03) |=> costCycles == 5'd0); // R9
  AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regRdData == $past(regWrData)); // R10
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(regRdData)); // R10

endmodule

bind wait_cost_calc wscalc_checker #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/sim_wait_cost_calc.sv
`timescale 1ns/1ps
module sim_wait_cost_calc;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqSeq = 1'b0;
  logic [1:0]  reqWidth = 2'b00;
  logic        hDrawActive = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        costValid;
  logic [4:0]  costCycles;

  int checks = 0;
  int errors = 0;
  logic [15:0] wcShadow = '0;

  always #2.5 clk = ~clk;

  wait_cost_calc u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSeq(reqSeq), .reqWidth(reqWidth), .hDrawActive(hDrawActive),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .costValid(costValid), .costCycles(costCycles)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected cost from the requirements
  function automatic int model(input logic [7:0] top, input logic s,
                               input logic [1:0] w, input logic hd,
                               input logic [15:0] wc);
    int nsTab[4] = '{4, 3, 2, 8};
    int sqTab[2] = '{2, 1};
    bit wide = (w == 2'b10);
    if (top == 8'h02) return wide ? 6 : 3;
    if (top == 8'h05 || top == 8'h06 || top == 8'h07) return (wide ? 2 : 1) + int'(hd);
    if (top == 8'h08 || top == 8'h0A || top == 8'h0C) begin
      int k = (int'(top) - 8) / 2;
      int f = int'(wc[2 + 3*k +: 2]);
      int q = int'(wc[4 + 3*k]);
      if (s) return wide ? 2 * sqTab[q] : sqTab[q];
      return wide ? nsTab[f] + sqTab[q] : nsTab[f];
    end
    return 0;
  endfunction

  task automatic writeReg(input logic [15:0] v, input string req);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
    wcShadow = v;
    check(req, int'(regRdData), int'(v));
  endtask

  task automatic doReq(input logic [7:0] top, input logic s, input logic [1:0] w,
                       input logic hd, input string req);
    int exp = model(top, s, w, hd, wcShadow);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = {top, 24'h5A5A5A}; reqSeq = s; reqWidth = w; hDrawActive = hd;
    @(negedge clk);
    reqValid = 1'b0; hDrawActive = ~hd;
    check({req, " valid"}, int'(costValid), 1);
    check(req, int'(costCycles), exp);
  endtask

  task automatic testReset();
    check("R1 rd", int'(regRdData), 0);
    check("R1 valid", int'(costValid), 0);
    check("R1 cost", int'(costCycles), 0);
  endtask

  task automatic testHold();
    doReq(8'h02, 1'b0, 2'b10, 1'b0, "R2 req");
    @(negedge clk);
    check("R2 pulse end", int'(costValid), 0);
    check("R2 hold", int'(costCycles), 6);
  endtask

  task automatic testExtRam();
    for (int w = 0; w < 4; w++) doReq(8'h02, 1'b1, 2'(w), 1'b0, "R3 R12 ext");
  endtask

  task automatic testVideo();
    for (int t = 5; t < 8; t++)
      for (int w = 0; w < 3; w++)
        for (int h = 0; h < 2; h++) doReq(8'(t), 1'b0, 2'(w), 1'(h), "R4 video");
  endtask

  task automatic testCart();
    for (int k = 0; k < 3; k++)
      for (int f = 0; f < 4; f++)
        for (int q = 0; q < 2; q++) begin
          logic [15:0] v = '0;
          for (int o = 0; o < 3; o++) begin
            v[2 + 3*o +: 2] = (o == k) ? 2'(f) : 2'(3 - f);
            v[4 + 3*o]      = (o == k) ? 1'(q) : 1'(1 - q);
          end
          writeReg(v, "R8 R10 load");
          doReq(8'(8 + 2*k), 1'b0, 2'b01, 1'b0, "R5 R8 nonseq16");
          doReq(8'(8 + 2*k), 1'b0, 2'b00, 1'b0, "R5 nonseq8");
          doReq(8'(8 + 2*k), 1'b1, 2'b01, 1'b0, "R6 R8 seq16");
          doReq(8'(8 + 2*k), 1'b0, 2'b10, 1'b0, "R7 nonseq32");
          doReq(8'(8 + 2*k), 1'b1, 2'b10, 1'b1, "R7 seq32");
          doReq(8'(8 + 2*k), 1'b0, 2'b11, 1'b0, "R12 rsv width");
        end
  endtask

  task automatic testOther();
    logic [7:0] tops[6] = '{8'h00, 8'h01, 8'h03, 8'h04, 8'h09, 8'hFF};
    writeReg(16'hFFFF, "R10 all ones");
    foreach (tops[i]) doReq(tops[i], 1'b0, 2'b10, 1'b1, "R9 other");
  endtask

  task automatic testUnusedBits();
    writeReg(16'hF803, "R10 spare bits");
    doReq(8'h08, 1'b0, 2'b01, 1'b0, "R10 no effect r0");
    doReq(8'h0A, 1'b1, 2'b10, 1'b0, "R10 no effect r1");
    doReq(8'h0C, 1'b0, 2'b10, 1'b0, "R10 no effect r2");
  endtask

  task automatic testCollision();
    writeReg(16'h0000, "R11 clear");
    @(negedge clk);
    regWrEn = 1'b1; regWrData = 16'h000C;
    reqValid = 1'b1; reqAddr = 32'h0800_0000; reqSeq = 1'b0; reqWidth = 2'b01;
    @(negedge clk);
    regWrEn = 1'b0; reqValid = 1'b0;
    check("R11 old value used", int'(costCycles), 4);
    check("R11 reg updated", int'(regRdData), 16'h000C);
    wcShadow = 16'h000C;
    doReq(8'h08, 1'b0, 2'b01, 1'b0, "R11 new value later");
    check("R11 direct", int'(costCycles), 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHold();
    testExtRam();
    testVideo();
    testCart();
    testOther();
    testUnusedBits();
    testCollision();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule